// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block produces one pulse-width-modulated output from an 8-bit timer with a programmable period. A small register-write port sets four values: the period, the upper eight bits of a 10-bit duty value, a control byte holding the two lowest duty bits and the PWM enable, and a timer control byte holding the timer run bit and the clock prescale select. The timer is extended below its least significant bit by two sub-count bits taken from the prescaler. The 10-bit duty is compared against this 10-bit count, so one duty step lasts one prescaled input clock.

The duty value written by software is only staged. At the end of each PWM cycle, when the timer has reached the period value and steps again, the staged duty is copied into a shadow register and the output goes high. The output falls when the 10-bit count reaches the shadow duty. A duty change made part way through a cycle therefore never shortens or stretches the pulse already in progress. A duty larger than the last count of the cycle keeps the output high for the whole cycle, and a duty of zero keeps it low.

With prescale N and period value P, one PWM cycle lasts (P+1)·4·N input clocks, and the output stays high for duty·N input clocks.

Top module: `dbuf_pwm`

## Requirements
- R1: After reset the output is low, the timer is stopped, the PWM enable is clear, the staged duty is zero and the period value is 0xFF. With no period write, the cycle is therefore 1024·N clocks long.
- R2: Register addresses are 0 for the period, 1 for the duty upper byte, 2 for the PWM control and 3 for the timer control. With the timer running and the output enabled, successive rising edges of the output are exactly (P+1)·4·N input clocks apart.
- R3: The duty value is {duty upper byte, PWM control bits [5:4]}, and the output stays high for duty·N input clocks of each cycle.
- R4: Timer control bits [1:0] select the prescale N: 00 gives 1, 01 gives 4, and both 10 and 11 give 16. Bit 2 runs the timer. Bits [6:3] have no effect.
- R5: A duty written during a cycle leaves that cycle's high time unchanged and takes effect from the next cycle.
- R6: If the duty is at least (P+1)·4, the output is never cleared and stays high continuously.
- R7: A duty of zero holds the output low continuously.
- R8: PWM control bit 0 enables the output. While it is clear, the output is low. After it is set, the output stays low until the first period rollover.
- R9: While timer control bit 2 is clear, the timer and prescaler hold their values and the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
A register write lands on the clock edge where wr_en is sampled. Period and prescale changes act from the next clock. A duty change acts only at the next rollover edge, which is also the edge where the output rises. The output falls on the edge where the extended count reaches the shadow duty, so the high time is duty·N clocks and the rise-to-rise spacing is the full cycle.

The scoreboard arms itself on a rising edge seen after all writes for a case have completed, so every measured cycle runs entirely under the new settings. Each later rise closes a cycle, and its high and period sample counts, taken on falling clock edges, are compared with the queued values. Level checks for the constant-output cases, and for the enable and timer-stop cases, wait at least two clocks after the last write before sampling.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;

    localparam int TMR_W     = 8;
    localparam int FRAC_W    = 2;
    localparam int SEL_W     = 2;
    localparam int DATA_W    = TMR_W;
    localparam int ADDR_W    = 2;
    localparam int DUTY_W    = TMR_W + FRAC_W;
    localparam int SHIFT_MAX = 4;
    localparam int PRE_W     = FRAC_W + SHIFT_MAX;

    localparam logic [ADDR_W-1:0] ADR_PERIOD = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DUTY   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_PCTL   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_TCTL   = 2'd3;

    localparam int PCTL_EN_BIT = 0;
    localparam int PCTL_LO_BIT = 4;
    localparam int TCTL_ON_BIT = 2;

    typedef struct packed {
        logic [TMR_W-1:0]  period;
        logic [TMR_W-1:0]  duty_hi;
        logic [FRAC_W-1:0] duty_lo;
        logic              pwm_en;
        logic              tmr_on;
        logic [SEL_W-1:0]  psel;
    } cfg_t;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [PRE_W-1:0] pre;
    } tb_state_t;

    typedef struct packed {
        logic [DUTY_W-1:0] shadow;
        logic              out;
    } out_state_t;

endpackage

// File: rtl/dbuf_pwm_regs.sv
module dbuf_pwm_regs
    import dbuf_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_PERIOD: cfg_d.period  = wr_data;
                ADR_DUTY:   cfg_d.duty_hi = wr_data;
                ADR_PCTL: begin
                    cfg_d.pwm_en  = wr_data[PCTL_EN_BIT];
                    cfg_d.duty_lo = wr_data[PCTL_LO_BIT +: FRAC_W];
                end
                ADR_TCTL: begin
                    cfg_d.tmr_on = wr_data[TCTL_ON_BIT];
                    cfg_d.psel   = wr_data[0 +: SEL_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.period <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == ADR_DUTY)) |=> $stable(cfg_q.duty_hi)); // R5

endmodule

// File: rtl/dbuf_pwm_timebase.sv
module dbuf_pwm_timebase
    import dbuf_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_i,
    input  logic [SEL_W-1:0]  psel_i,
    input  logic [TMR_W-1:0]  period_i,
    output logic [DUTY_W-1:0] cnt_nxt_o,
    output logic              wrap_o
);

    tb_state_t st_d, st_q;
    logic [2:0]        shift;
    logic [PRE_W-1:0]  lim;
    logic              tick;
    logic              wrap;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        case (psel_i)
            2'b00:   shift = 3'd0;
            2'b01:   shift = 3'd2;
            default: shift = 3'd4;
        endcase
        lim  = PRE_W'((1 << (FRAC_W + int'(shift))) - 1);
        tick = on_i && (st_q.pre >= lim);
        wrap = 1'b0;
        st_d = st_q;
        if (on_i) begin
            if (tick) begin
                st_d.pre = '0;
                if (st_q.tmr == period_i) begin
                    st_d.tmr = '0;
                    wrap     = 1'b1;
                end else begin
                    st_d.tmr = st_q.tmr + TMR_W'(1);
                end
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
        frac = st_d.pre[shift +: FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_nxt_o = {st_d.tmr, frac};
    assign wrap_o    = wrap;

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.tmr == '0) && (st_q.pre == '0)); // R2

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> $stable(st_q)); // R9

endmodule

// File: rtl/dbuf_pwm_out.sv
module dbuf_pwm_out
    import dbuf_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wrap_i,
    input  logic [DUTY_W-1:0] cnt_nxt_i,
    input  logic [DUTY_W-1:0] staged_i,
    output logic              pwm_o
);

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            st_d.shadow = staged_i;
            st_d.out    = (staged_i != '0);
        end else if (cnt_nxt_i == st_q.shadow) begin
            st_d.out = 1'b0;
        end
        if (!en_i) begin
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.out;

    AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.out) |-> $past(wrap_i)); // R2

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.shadow == '0) |-> !st_q.out); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap_i) |-> $stable(st_q.shadow)); // R5

    AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.out); // R8

endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
    import dbuf_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);

    cfg_t              cfg;
    logic [DUTY_W-1:0] cnt_nxt;
    logic              wrap;

    dbuf_pwm_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_o   (cfg)
    );

    dbuf_pwm_timebase i_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_i      (cfg.tmr_on),
        .psel_i    (cfg.psel),
        .period_i  (cfg.period),
        .cnt_nxt_o (cnt_nxt),
        .wrap_o    (wrap)
    );

    dbuf_pwm_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (cfg.pwm_en),
        .wrap_i    (wrap),
        .cnt_nxt_i (cnt_nxt),
        .staged_i  ({cfg.duty_hi, cfg.duty_lo}),
        .pwm_o     (pwm_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk) $past(!rst_n) |-> !pwm_out); // R1

endmodule

// File: tb/test_dbuf_pwm.sv
module test_dbuf_pwm;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       pwm_out;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int    hi;
        int    per;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    bit   mon_sync = 1'b0;

    always #10 clk = ~clk;

    dbuf_pwm i_dbuf_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [7:0] pctl(input logic [1:0] lo, input bit en);
        return {2'b00, lo, 3'b000, en};
    endfunction

    // monitor: measures each full cycle between rising edges
    bit prev_p  = 1'b0;
    bit armed   = 1'b0;
    int hi_cnt  = 0;
    int per_cnt = 0;

    always @(negedge clk) begin
        if (mon_sync) begin
            armed    = 1'b0;
            mon_sync = 1'b0;
        end
        if (pwm_out && !prev_p) begin
            if (armed && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(hi_cnt == e.hi, {e.tag, " high"}, hi_cnt, e.hi);
                chk(per_cnt == e.per, {e.tag, " period"}, per_cnt, e.per);
            end
            armed   = 1'b1;
            hi_cnt  = 1;
            per_cnt = 1;
        end else begin
            per_cnt++;
            if (pwm_out) hi_cnt++;
        end
        prev_p = pwm_out;
    end

    task automatic push(input int hi, input int per, input string tag);
        exp_t e;
        e.hi  = hi;
        e.per = per;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic arm();
        @(posedge pwm_out);
        mon_sync = 1'b1;
    endtask

    task automatic run_case(input logic [7:0] per, input logic [7:0] dhi, input logic [1:0] dlo,
                            input logic [7:0] tctl, input int hi, input int clks,
                            input int n, input string tag);
        wr(2'd0, per);
        wr(2'd1, dhi);
        wr(2'd2, pctl(dlo, 1'b1));
        wr(2'd3, tctl);
        arm();
        for (int i = 0; i < n; i++) push(hi, clks, tag);
        wait (exp_q.size() == 0);
    endtask

    task automatic count_high(input int n, output int highs, output int changes);
        bit last;
        highs   = 0;
        changes = 0;
        @(negedge clk);
        last = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out != last) changes++;
            last = pwm_out;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int h;
        int c;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R1 reset output", int'(pwm_out), 0);

        // R1: default period 0xFF, duty 0x80:2 = 514, prescale 1
        wr(2'd1, 8'h80);
        wr(2'd2, pctl(2'd2, 1'b1));
        wr(2'd3, 8'h04);
        // R8: low until first rollover (1024 clocks away)
        count_high(600, h, c);
        chk(h == 0, "R8 low before first rollover", h, 0);
        arm();
        push(514, 1024, "R1");
        wait (exp_q.size() == 0);

        // R3 with postscale bits set (R4 ignored field): period 3, duty 9
        run_case(8'd3, 8'd2, 2'd1, 8'h7C, 9, 16, 3, "R3");
        // R3 boundary: largest duty that still clears
        run_case(8'd3, 8'd3, 2'd3, 8'h04, 15, 16, 2, "R3");
        // R4 prescale variants
        run_case(8'd9, 8'd5, 2'd3, 8'h05, 92, 160, 2, "R4");
        run_case(8'd4, 8'd1, 2'd0, 8'h06, 64, 320, 2, "R4");
        run_case(8'd2, 8'd0, 2'd3, 8'h07, 48, 192, 2, "R4");

        // R5: mid-cycle duty write from 10 to 20, period 7
        run_case(8'd7, 8'd2, 2'd2, 8'h04, 10, 32, 0, "R5");
        arm();
        push(10, 32, "R5");
        repeat (2) @(negedge clk);
        wr(2'd1, 8'd5);
        wr(2'd2, pctl(2'd0, 1'b1));
        chk(pwm_out == 1'b1, "R5 pulse unaffected", int'(pwm_out), 1);
        push(20, 32, "R5");
        push(20, 32, "R5");
        wait (exp_q.size() == 0);

        // R6: duty 16 with period 3 (last count 15)
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd4);
        wr(2'd2, pctl(2'd0, 1'b1));
        repeat (1200) @(negedge clk);
        count_high(64, h, c);
        chk(h == 64, "R6 always high", h, 64);

        // R7: duty 0
        wr(2'd1, 8'd0);
        wr(2'd2, pctl(2'd0, 1'b1));
        repeat (40) @(negedge clk);
        count_high(48, h, c);
        chk(h == 0, "R7 always low", h, 0);

        // R9: stop timer during a high phase, duty 8
        wr(2'd1, 8'd2);
        repeat (40) @(negedge clk);
        @(posedge pwm_out);
        wr(2'd3, 8'h00);
        repeat (2) @(negedge clk);
        count_high(100, h, c);
        chk(c == 0, "R9 frozen output changes", c, 0);
        chk(h == 100, "R9 frozen output level", h, 100);

        // R8: enable cleared forces low
        wr(2'd3, 8'h04);
        wr(2'd2, pctl(2'd0, 1'b0));
        repeat (2) @(negedge clk);
        count_high(40, h, c);
        chk(h == 0, "R8 disabled low", h, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule